// File: doc/BRIEF.md
# Page-Linked Event Counter Bank

This block keeps four read-only event counters, each tied to one page of a paged memory. The memory has sixteen pages of 256 bits each, and the counters belong to its last four pages. Two of the counters track completed write cycles to their own page. The memory controller reports each finished page write with a one-cycle strobe and the page index. The other two counters track presses of external switches, such as reed or Wiegand switches. These switches drive two asynchronous active-low pins. Each pin passes through a synchronizer and a debouncer, so a contact that bounces still adds only one count.

Nothing can load a value into the bank. The only way to change a counter is to clear all of them at power-up. A bus-side reader picks a counter with a select input and receives its value one clock later. Every counter wraps from all-ones back to zero.

Top module: `pgevt_counter_bank`

## Requirements
- R1: `rd_data` shows the counter picked by `rd_sel` (0 to 3), and the value appears one clock after the select is sampled.
- R2: Counter i belongs to page 12+i. Counter 0 adds one for each cycle in which `wr_done` is high and `wr_page` is 12. Counter 1 does the same for page 13.
- R3: A strobe on `wr_done` with a page other than 12 or 13 changes no counter, and neither does `wr_page` while `wr_done` is low.
- R4: An accepted high-to-low change on `trig_a_n` adds one to counter 2. An accepted high-to-low change on `trig_b_n` adds one to counter 3.
- R5: A new trigger level is accepted only after its synchronized value has held for DEB_CYCLES (default 16) clocks in a row. The bench checks this boundary with a low level held for 15 clocks (not accepted) and one held for 16 clocks (accepted). A burst of short bounces that ends in a held low gives exactly one count.
- R6: The return of a trigger from low to high never adds a count.
- R7: A counter that holds all-ones reads zero after its next event.
- R8: While `rst_n` is low at a clock edge, every counter and `rd_data` become zero.
- R9: If a counter is read in the same cycle that it increments, the read returns the value from before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| trig_a_n | input | 1 | Asynchronous active-low switch input for counter 2 |
| trig_b_n | input | 1 | Asynchronous active-low switch input for counter 3 |
| wr_done | input | 1 | One-cycle strobe marking a completed page write |
| wr_page | input | PAGE_W (4) | Index of the page that was written |
| rd_sel | input | 2 | Counter to read |
| rd_data | output | CNT_W (32) | Value of the selected counter, registered |

## Verification
Page-write strobes go to pages 12 and 13 and also to every other page. This shows whether each counter decodes only its own page. On the switch inputs, the bench drives a clean press, a glitch, low pulses of 15 and 16 clocks, and a bouncing press and release. These separate a correct debounce window from one that is off by a cycle, from edge detection on the wrong polarity, and from counting bounces. A read taken in the cycle of an increment tells a registered read of the old value apart from a pass-through of the new one. A second instance with 4-bit counters reaches the wrap point, so the bench can check the wrap to zero.

// File: rtl/evtcnt_pkg.sv
// Package: shared constants for the page-linked event counter bank.
// Assumes a fixed bank layout of two write-cycle counters followed by two trigger counters.
package evtcnt_pkg;
    localparam int unsigned NUM_CNT  = 4;
    localparam int unsigned NUM_WR   = 2;
    localparam int unsigned NUM_TRIG = NUM_CNT - NUM_WR;
    localparam int unsigned SEL_W    = $clog2(NUM_CNT);
endpackage

// File: rtl/evtcnt_sync.sv
// Module: two-flop synchronizer for one asynchronous level input.
// Assumes the input is a slow level signal. Reset loads the idle value IDLE.
module evtcnt_sync #(
    parameter logic IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    // Purpose: move the pin into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= IDLE;
            sync_out <= IDLE;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/evtcnt_debounce.sv
// Module: debouncer with a falling-edge detector for an active-low switch input.
// A new level is accepted only after the synchronized input has differed from the
// accepted level for STABLE_CYC samples in a row. Each accepted high-to-low change
// produces a one-cycle pulse on fall_pulse.
// Assumes: the input is already synchronous, the idle level is high, and STABLE_CYC >= 2.
module evtcnt_debounce #(
    parameter int unsigned STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic fall_pulse
);
    localparam int unsigned RUN_W = $clog2(STABLE_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(STABLE_CYC - 1);

    logic             acc_lvl;
    logic [RUN_W-1:0] run_q;

    // Purpose: count consecutive differing samples, accept the level, and pulse on a fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_lvl    <= 1'b1;
            run_q      <= '0;
            fall_pulse <= 1'b0;
        end else begin
            fall_pulse <= 1'b0;
            if (lvl_in == acc_lvl) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                acc_lvl    <= lvl_in;
                run_q      <= '0;
                fall_pulse <= ~lvl_in;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R5: the accepted level changes only at the end of a full stability window
    assert_window_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable(acc_lvl) |-> $past(run_q) == RUN_LAST);

    // R5: one accepted change gives exactly one pulse
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |=> !fall_pulse);

    // R6: a pulse comes only from a change to the low level
    assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> !acc_lvl && $past(acc_lvl));
endmodule

// File: rtl/evtcnt_reg.sv
// Module: one wrapping event counter.
// Adds one on each cycle in which bump is high, rolls from all-ones to zero,
// and clears on reset. It has no load path.
module evtcnt_reg #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] value
);
    // Purpose: clear on reset and add one on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (bump) begin
            value <= value + 1'b1;
        end
    end

    // R7: each event adds exactly one, modulo 2^CNT_W
    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> value == CNT_W'($past(value) + 1'b1));

    // R3: without an event the count holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(value));

    // R8: the edge after a reset cycle sees zero
    assert_clear_R8: assert property (@(posedge clk)
        !rst_n |=> value == '0);
endmodule

// File: rtl/pgevt_counter_bank.sv
// Module: bank of four read-only counters bound to memory pages PAGE_BASE..PAGE_BASE+3.
// Counters 0 and 1 count completed writes to their pages. Counters 2 and 3 count
// debounced falls of trig_a_n and trig_b_n. The read port is registered and has
// one cycle of latency.
// Assumes wr_done is a one-cycle strobe per completed page write. Trigger pins are
// asynchronous and idle high.
module pgevt_counter_bank
    import evtcnt_pkg::*;
#(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned PAGE_W     = 4,
    parameter int unsigned PAGE_BASE  = 12,
    parameter int unsigned DEB_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_a_n,
    input  logic              trig_b_n,
    input  logic              wr_done,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  rd_data
);
    logic [NUM_TRIG-1:0] trig_n;
    logic [NUM_CNT-1:0]  bump;
    logic [CNT_W-1:0]    cnt_vec [NUM_CNT];

    assign trig_n = {trig_b_n, trig_a_n};

    // Write-cycle counters: decode the page of each completed write.
    for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
        assign bump[w] = wr_done && (wr_page == PAGE_W'(PAGE_BASE + w));
    end

    // Trigger counters: synchronize, then debounce, then detect the fall.
    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        logic trig_sync;

        evtcnt_sync #(.IDLE(1'b1)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (trig_n[t]),
            .sync_out (trig_sync)
        );

        evtcnt_debounce #(.STABLE_CYC(DEB_CYCLES)) u_deb (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_in     (trig_sync),
            .fall_pulse (bump[NUM_WR + t])
        );
    end

    // One counter per page.
    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        evtcnt_reg #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .bump  (bump[c]),
            .value (cnt_vec[c])
        );
    end

    // Purpose: register the selected count, giving the value from before any same-cycle bump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= cnt_vec[rd_sel];
        end
    end

    // R1 and R9: the output shows last cycle's value of the selected counter
    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_data == $past(cnt_vec[rd_sel]));

    // R3: a write to a page outside the write-counter pages leaves both write counters alone
    assert_foreign_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_page != PAGE_W'(PAGE_BASE)) && (wr_page != PAGE_W'(PAGE_BASE + 1))
        |=> $stable(cnt_vec[0]) && $stable(cnt_vec[1]));

    // R4: page writes never reach the trigger counters
    assert_trig_isolated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bump[NUM_CNT-1:NUM_WR]) == 0 |=>
        $stable(cnt_vec[NUM_WR]) && $stable(cnt_vec[NUM_CNT-1]));
endmodule

// File: tb/pgevt_counter_bank_tb.sv
module pgevt_counter_bank_tb;
    localparam int DEB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_a_n = 1'b1;
    logic        trig_b_n = 1'b1;
    logic        wr_done = 1'b0;
    logic [3:0]  wr_page = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [3:0]  rd_w4;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    longint unsigned exp_cnt [4];

    always #2.5 clk = ~clk;

    pgevt_counter_bank #(.CNT_W(32), .DEB_CYCLES(DEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_a_n(trig_a_n), .trig_b_n(trig_b_n),
        .wr_done(wr_done), .wr_page(wr_page), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    pgevt_counter_bank #(.CNT_W(4), .DEB_CYCLES(DEB)) u_dut_w4 (
        .clk(clk), .rst_n(rst_n), .trig_a_n(trig_a_n), .trig_b_n(trig_b_n),
        .wr_done(wr_done), .wr_page(wr_page), .rd_sel(rd_sel), .rd_data(rd_w4)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic read_cnt(input int idx, output logic [31:0] v, output logic [3:0] v4);
        @(negedge clk) rd_sel = 2'(idx);
        @(posedge clk);
        @(negedge clk);
        v = rd_data;
        v4 = rd_w4;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        logic [3:0]  v4;
        for (int i = 0; i < 4; i++) begin
            read_cnt(i, v, v4);
            check($sformatf("%s cnt%0d", req, i), v, exp_cnt[i]);
        end
    endtask

    task automatic page_write(input int pg);
        @(negedge clk);
        wr_done = 1'b1;
        wr_page = 4'(pg);
        @(negedge clk);
        wr_done = 1'b0;
    endtask

    task automatic hold_a(input logic lvl, input int cyc);
        @(negedge clk) trig_a_n = lvl;
        repeat (cyc - 1) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
    endtask

    // R8: after a clear, every counter and the read port are zero
    task automatic t_reset();
        check("R8 rd_data after reset", rd_data, 0);
        check_all("R8");
    endtask

    // R2: writes to pages 12 and 13 reach counters 0 and 1
    task automatic t_page_writes();
        for (int k = 0; k < 3; k++) page_write(12);
        for (int k = 0; k < 5; k++) page_write(13);
        exp_cnt[0] = 3;
        exp_cnt[1] = 5;
        check_all("R2");
    endtask

    // R3: other pages, and wr_page alone without the strobe, change nothing
    task automatic t_other_pages();
        for (int p = 0; p < 16; p++)
            if (p != 12 && p != 13) page_write(p);
        @(negedge clk) wr_page = 4'd12;
        repeat (4) @(negedge clk);
        check_all("R3");
    endtask

    // R4: clean presses on A and then on B
    task automatic t_triggers();
        hold_a(1'b0, 30);
        hold_a(1'b1, 30);
        exp_cnt[2] = 1;
        check_all("R4 A");
        @(negedge clk) trig_b_n = 1'b0;
        repeat (30) @(negedge clk);
        trig_b_n = 1'b1;
        repeat (30) @(negedge clk);
        exp_cnt[3] = 1;
        check_all("R4 B");
    endtask

    // R5: a glitch and a 15-clock low are rejected, a 16-clock low is accepted
    task automatic t_debounce_window();
        hold_a(1'b0, 5);
        hold_a(1'b1, 30);
        check_all("R5 glitch");
        hold_a(1'b0, DEB - 1);
        hold_a(1'b1, 30);
        check_all("R5 15-cycle low");
        hold_a(1'b0, DEB);
        hold_a(1'b1, 30);
        exp_cnt[2] += 1;
        check_all("R5 16-cycle low");
    endtask

    // R5 and R6: a bouncing press counts once, and a bouncing release counts nothing
    task automatic t_bounce();
        for (int k = 0; k < 6; k++) begin
            hold_a(1'b0, 3);
            hold_a(1'b1, 2);
        end
        hold_a(1'b0, 30);
        exp_cnt[2] += 1;
        check_all("R5 bounce press");
        for (int k = 0; k < 6; k++) begin
            hold_a(1'b1, 3);
            hold_a(1'b0, 2);
        end
        hold_a(1'b1, 30);
        check_all("R6 bounce release");
    endtask

    // R9: a read in the cycle of an increment returns the old value
    task automatic t_same_cycle();
        @(negedge clk);
        rd_sel = 2'd0;
        wr_done = 1'b1;
        wr_page = 4'd12;
        @(negedge clk);
        wr_done = 1'b0;
        check("R9 same-cycle read", rd_data, exp_cnt[0]);
        @(negedge clk);
        exp_cnt[0] += 1;
        check("R1 next-cycle read", rd_data, exp_cnt[0]);
    endtask

    // R7: the 4-bit instance wraps at all-ones, the 32-bit one does not
    task automatic t_wrap();
        logic [31:0] v;
        logic [3:0]  v4;
        for (int k = 0; k < 15; k++) page_write(12);
        read_cnt(0, v, v4);
        check("R7 all-ones before wrap", v4, 15);
        page_write(12);
        read_cnt(0, v, v4);
        check("R7 wrap to zero", v4, 0);
        check("R7 wide counter keeps counting", v, 16);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page_writes();
        t_other_pages();
        t_triggers();
        t_debounce_window();
        t_bounce();
        t_same_cycle();
        do_reset();
        t_reset();
        t_wrap();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule